// File: doc/BRIEF.md
# Variable-Length Instruction Format Decoder

This block looks at the first ten bytes fetched at the program counter of a 64-bit machine whose instructions are 2, 3, 6, 7 or 10 bytes long. It reports how long the instruction is and which class it belongs to. It also pulls out the register fields, the address scale, a 32-bit immediate and a 32-bit branch or call target. The fetch unit uses the length to step the program counter. The execute stage uses the class flags and fields without decoding the bytes again.

The first byte holds the major opcode in its high nibble and the minor opcode in its low nibble. The major opcode fixes the format, and the format fixes both the length and the byte offsets of the 32-bit fields. Any byte pattern that is not a defined instruction raises an illegal flag. In that case the block reports a length of 2 and leaves the immediate and target at zero. The decode logic is purely combinational. A parameter can place one register stage on all outputs.

Top module: `vlen_insn_decoder`

## Requirements
- R1: For a legal instruction, the length is 2 for majors 0, 1, 2, 3 and 8. It is 3 for major 9, 6 for majors 4, 5, 6, 7 and A, 7 for major B, and 10 for major F.
- R2: `rd_o` is byte 1 bits [7:4], and `rs_o` is byte 1 bits [3:0]. `rz_o` is byte 2 bits [7:4], and `scale_o` is byte 2 bits [1:0], where scale code c means a multiplier of 2^c. All four are passed through for every byte pattern.
- R3: The illegal flag is raised in these cases:
  - majors C, D and E;
  - any minor value that R4 to R7 do not list;
  - byte 0 = 0x00 with byte 1 not zero;
  - byte 0 = 0x01 with byte 1 bits [7:4] not zero;
  - majors 9 and B with a scale code (byte 2 bits [3:0]) above 3.
  
  An illegal decode gives length 2, no other class flag, and zero immediate and target.
- R4: Bytes 0x00 0x00 decode as stop. Byte 0 = 0x01 with byte 1 bits [7:4] = 0 decodes as return, with the return register in `rs_o`.
- R5: Opcodes 0x31 and 0x75 are loads, and 0x39 and 0x7D are stores. Minor bit 3 selects the direction.
- R6: Condition codes 0, 1 and 4 to 11 are valid. In major 4, minor 0xE is a call, minor 0xF is an unconditional jump, and a valid condition code is a conditional branch. In major F, a valid condition code is a conditional branch. Codes 2, 3 and 12 to 15 are illegal, except for 0xE and 0xF in major 4.
- R7: Minors 0 to 9 give register arithmetic in major 1 and immediate arithmetic in major 5. Opcodes 0x21 and 0x64 are moves. Opcodes 0x81, 0x92, 0x93, 0xA4, 0xA5, 0xB6 and 0xB7 are address computations.
- R8: The immediate is read from 4 little-endian bytes and sign-extended to 64 bits. It starts at byte 2 for majors 5, 6, 7, A and F, and at byte 3 for major B. It is zero for every other format.
- R9: The target is read from 4 little-endian bytes and zero-extended to 64 bits. It starts at byte 2 for major 4 and at byte 6 for major F. It is zero otherwise.
- R10: With `REG_OUT` = 1, every output shows the decode of the input one clock edge later. Every output is zero while `rst_n` is low. With `REG_OUT` = 0, the outputs follow the input combinationally.
- R11: Every decode raises exactly one of the twelve class flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_i | input | 80 | Instruction bytes; byte k at bits [8k+7:8k] |
| len_o | output | 4 | Instruction length in bytes |
| rd_o | output | 4 | Register d field |
| rs_o | output | 4 | Register s field |
| rz_o | output | 4 | Index register z field |
| scale_o | output | 2 | Scale shift amount |
| imm_o | output | 64 | Sign-extended immediate |
| tgt_o | output | 64 | Zero-extended target address |
| is_stop_o | output | 1 | Stop |
| is_ret_o | output | 1 | Return through register s |
| is_alu_rr_o | output | 1 | Register/register arithmetic |
| is_alu_ri_o | output | 1 | Immediate/register arithmetic |
| is_mov_o | output | 1 | Register or constant move |
| is_load_o | output | 1 | Memory load |
| is_store_o | output | 1 | Memory store |
| is_lea_o | output | 1 | Address computation |
| is_call_o | output | 1 | Call |
| is_jmp_o | output | 1 | Unconditional jump |
| is_cbr_o | output | 1 | Conditional compare-and-branch |
| is_illegal_o | output | 1 | Undefined encoding |

## Verification
The sweep covers every value of byte 0, combined with byte 1 patterns that make stop and return legal or illegal and byte 2 patterns with legal and illegal scale codes.

The bench looks for these faults:
- A wrong length entry shows up as a misaligned program-counter step.
- Reading the field of the 7-byte or 10-byte form at the 6-byte offset gives a wrong immediate or target.
- Zero-extending the immediate, or sign-extending the target, fails on patterns whose top byte has bit 7 set.
- Treating unassigned condition codes or an oversized scale as legal shows up as a missing illegal flag, or as a length other than 2.

// File: rtl/vid_pkg.sv
package vid_pkg;
  localparam int BYTE_W      = 8;
  localparam int INSN_BYTES  = 10;
  localparam int INSN_W      = BYTE_W * INSN_BYTES;
  localparam int XLEN        = 64;
  localparam int FIELD_BYTES = 4;
  localparam int FIELD_W     = BYTE_W * FIELD_BYTES;
  localparam int NIB_W       = 4;
  localparam int LEN_W       = 4;
  localparam int OFS_W       = 3;
  localparam int SCALE_CODES = 4;
  localparam int SCALE_W     = $clog2(SCALE_CODES);
  localparam int COND_LIMIT  = 11;
  localparam int ALU_OPS     = 10;

  typedef struct packed {
    logic stop;
    logic ret;
    logic alu_rr;
    logic alu_ri;
    logic mov;
    logic load;
    logic store;
    logic lea;
    logic call;
    logic jmp;
    logic cbr;
    logic illegal;
  } kind_t;

  typedef struct packed {
    logic [LEN_W-1:0]   len;
    kind_t              kind;
    logic [NIB_W-1:0]   rd;
    logic [NIB_W-1:0]   rs;
    logic [NIB_W-1:0]   rz;
    logic [SCALE_W-1:0] scale;
    logic [XLEN-1:0]    imm;
    logic [XLEN-1:0]    tgt;
  } dec_t;

  // Condition codes with a meaning: equal, not equal, and the eight ordered compares.
  function automatic logic cond_valid(input logic [NIB_W-1:0] code);
    return (code <= NIB_W'(1)) ||
           ((code >= NIB_W'(4)) && (code <= NIB_W'(COND_LIMIT)));
  endfunction

  // Length follows from the format, which the major opcode selects.
  function automatic logic [LEN_W-1:0] major_len(input logic [NIB_W-1:0] major);
    logic [LEN_W-1:0] n;
    case (major)
      4'h9:                         n = LEN_W'(3);
      4'h4, 4'h5, 4'h6, 4'h7, 4'hA: n = LEN_W'(6);
      4'hB:                         n = LEN_W'(7);
      4'hF:                         n = LEN_W'(10);
      default:                      n = LEN_W'(2);
    endcase
    return n;
  endfunction

  // Gather FIELD_BYTES little-endian bytes starting at byte ofs of the full
  // instruction; tail holds bytes 1 and up (byte 0 never carries a field).
  function automatic logic [FIELD_W-1:0] pick_field(
      input logic [INSN_W-BYTE_W-1:0] tail, input logic [OFS_W-1:0] ofs);
    logic [FIELD_W-1:0] f;
    int base;
    f = '0;
    for (int k = 0; k < FIELD_BYTES; k++) begin
      base = (int'(ofs) - 1 + k) * BYTE_W;
      if (base >= 0 && base + BYTE_W <= INSN_W - BYTE_W)
        f[k*BYTE_W +: BYTE_W] = tail[base +: BYTE_W];
    end
    return f;
  endfunction

  function automatic logic [XLEN-1:0] sext_field(input logic [FIELD_W-1:0] v);
    return {{(XLEN-FIELD_W){v[FIELD_W-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] zext_field(input logic [FIELD_W-1:0] v);
    return {{(XLEN-FIELD_W){1'b0}}, v};
  endfunction
endpackage

// File: rtl/vid_classify.sv
module vid_classify
  import vid_pkg::*;
(
  input  logic [BYTE_W-1:0] op_i,
  input  logic [BYTE_W-1:0] regs_i,
  input  logic [NIB_W-1:0]  scode_i,
  output kind_t             kind_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              imm_en_o,
  output logic [OFS_W-1:0]  imm_ofs_o,
  output logic              tgt_en_o,
  output logic [OFS_W-1:0]  tgt_ofs_o
);
  logic [NIB_W-1:0] major_w;
  logic [NIB_W-1:0] minor_w;
  logic             scale_ok_w;
  logic             cond_ok_w;
  logic             legal_w;
  logic             alu_minor_w;
  kind_t            kind_w;

  assign major_w     = op_i[BYTE_W-1 -: NIB_W];
  assign minor_w     = op_i[NIB_W-1:0];
  assign scale_ok_w  = (scode_i < NIB_W'(SCALE_CODES));
  assign cond_ok_w   = cond_valid(minor_w);
  assign alu_minor_w = (minor_w < NIB_W'(ALU_OPS));

  always_comb begin
    kind_w = '0;
    case (major_w)
      4'h0: begin
        kind_w.stop = (minor_w == 4'h0) && (regs_i == '0);
        kind_w.ret  = (minor_w == 4'h1) && (regs_i[BYTE_W-1 -: NIB_W] == '0);
      end
      4'h1: kind_w.alu_rr = alu_minor_w;
      4'h2: kind_w.mov    = (minor_w == 4'h1);
      4'h3: begin
        kind_w.load  = (minor_w == 4'h1);
        kind_w.store = (minor_w == 4'h9);
      end
      4'h4: begin
        kind_w.call = (minor_w == 4'hE);
        kind_w.jmp  = (minor_w == 4'hF);
        kind_w.cbr  = cond_ok_w;
      end
      4'h5: kind_w.alu_ri = alu_minor_w;
      4'h6: kind_w.mov    = (minor_w == 4'h4);
      4'h7: begin
        kind_w.load  = (minor_w == 4'h5);
        kind_w.store = (minor_w == 4'hD);
      end
      4'h8: kind_w.lea = (minor_w == 4'h1);
      4'h9: kind_w.lea = ((minor_w == 4'h2) || (minor_w == 4'h3)) && scale_ok_w;
      4'hA: kind_w.lea = (minor_w == 4'h4) || (minor_w == 4'h5);
      4'hB: kind_w.lea = ((minor_w == 4'h6) || (minor_w == 4'h7)) && scale_ok_w;
      4'hF: kind_w.cbr = cond_ok_w;
      default: kind_w = '0;
    endcase
    legal_w        = |kind_w;
    kind_w.illegal = ~legal_w;
  end

  assign kind_o    = kind_w;
  assign len_o     = legal_w ? major_len(major_w) : LEN_W'(2);
  assign imm_en_o  = legal_w && ((major_w == 4'h5) || (major_w == 4'h6) ||
                                 (major_w == 4'h7) || (major_w == 4'hA) ||
                                 (major_w == 4'hB) || (major_w == 4'hF));
  assign imm_ofs_o = (major_w == 4'hB) ? OFS_W'(3) : OFS_W'(2);
  assign tgt_en_o  = legal_w && ((major_w == 4'h4) || (major_w == 4'hF));
  assign tgt_ofs_o = (major_w == 4'hF) ? OFS_W'(6) : OFS_W'(2);
endmodule

// File: rtl/vid_fields.sv
module vid_fields
  import vid_pkg::*;
(
  input  logic [INSN_W-BYTE_W-1:0] tail_i,
  input  logic                     imm_en_i,
  input  logic [OFS_W-1:0]         imm_ofs_i,
  input  logic                     tgt_en_i,
  input  logic [OFS_W-1:0]         tgt_ofs_i,
  output logic [NIB_W-1:0]         rd_o,
  output logic [NIB_W-1:0]         rs_o,
  output logic [NIB_W-1:0]         rz_o,
  output logic [SCALE_W-1:0]       scale_o,
  output logic [XLEN-1:0]          imm_o,
  output logic [XLEN-1:0]          tgt_o
);
  logic [FIELD_W-1:0] imm_raw_w;
  logic [FIELD_W-1:0] tgt_raw_w;
  logic [BYTE_W-1:0]  reg_byte_w;
  logic [BYTE_W-1:0]  idx_byte_w;

  assign reg_byte_w = tail_i[0 +: BYTE_W];
  assign idx_byte_w = tail_i[BYTE_W +: BYTE_W];
  assign rd_o       = reg_byte_w[BYTE_W-1 -: NIB_W];
  assign rs_o       = reg_byte_w[NIB_W-1:0];
  assign rz_o       = idx_byte_w[BYTE_W-1 -: NIB_W];
  assign scale_o    = idx_byte_w[SCALE_W-1:0];

  assign imm_raw_w  = pick_field(tail_i, imm_ofs_i);
  assign tgt_raw_w  = pick_field(tail_i, tgt_ofs_i);
  assign imm_o      = imm_en_i ? sext_field(imm_raw_w) : '0;
  assign tgt_o      = tgt_en_i ? zext_field(tgt_raw_w) : '0;
endmodule

// File: rtl/vid_outreg.sv
module vid_outreg
  import vid_pkg::*;
#(
  parameter int REG_OUT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  dec_t d_i,
  output dec_t q_o
);
  logic past_ok_q;

  generate
    if (REG_OUT != 0) begin : g_reg
      dec_t q_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= d_i;
      end
      assign q_o = q_r;
    end else begin : g_wire
      assign q_o = d_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok_q <= 1'b0;
    else        past_ok_q <= 1'b1;
  end

  // R10: registered variant shows last edge's decode, wire variant the present one
  a_r10_stage_latency: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q |-> (q_o == ((REG_OUT != 0) ? $past(d_i) : d_i)));
endmodule

// File: rtl/vlen_insn_decoder.sv
module vlen_insn_decoder
  import vid_pkg::*;
#(
  parameter int REG_OUT = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [INSN_W-1:0]      insn_i,
  output logic [LEN_W-1:0]       len_o,
  output logic [NIB_W-1:0]       rd_o,
  output logic [NIB_W-1:0]       rs_o,
  output logic [NIB_W-1:0]       rz_o,
  output logic [SCALE_W-1:0]     scale_o,
  output logic [XLEN-1:0]        imm_o,
  output logic [XLEN-1:0]        tgt_o,
  output logic                   is_stop_o,
  output logic                   is_ret_o,
  output logic                   is_alu_rr_o,
  output logic                   is_alu_ri_o,
  output logic                   is_mov_o,
  output logic                   is_load_o,
  output logic                   is_store_o,
  output logic                   is_lea_o,
  output logic                   is_call_o,
  output logic                   is_jmp_o,
  output logic                   is_cbr_o,
  output logic                   is_illegal_o
);
  kind_t            kind_w;
  logic [LEN_W-1:0] len_w;
  logic             imm_en_w;
  logic [OFS_W-1:0] imm_ofs_w;
  logic             tgt_en_w;
  logic [OFS_W-1:0] tgt_ofs_w;
  dec_t             nxt_w;
  dec_t             out_w;

  vid_classify u_classify (
    .op_i      (insn_i[0 +: BYTE_W]),
    .regs_i    (insn_i[BYTE_W +: BYTE_W]),
    .scode_i   (insn_i[2*BYTE_W +: NIB_W]),
    .kind_o    (kind_w),
    .len_o     (len_w),
    .imm_en_o  (imm_en_w),
    .imm_ofs_o (imm_ofs_w),
    .tgt_en_o  (tgt_en_w),
    .tgt_ofs_o (tgt_ofs_w)
  );

  vid_fields u_fields (
    .tail_i    (insn_i[INSN_W-1:BYTE_W]),
    .imm_en_i  (imm_en_w),
    .imm_ofs_i (imm_ofs_w),
    .tgt_en_i  (tgt_en_w),
    .tgt_ofs_i (tgt_ofs_w),
    .rd_o      (nxt_w.rd),
    .rs_o      (nxt_w.rs),
    .rz_o      (nxt_w.rz),
    .scale_o   (nxt_w.scale),
    .imm_o     (nxt_w.imm),
    .tgt_o     (nxt_w.tgt)
  );

  assign nxt_w.len  = len_w;
  assign nxt_w.kind = kind_w;

  vid_outreg #(.REG_OUT(REG_OUT)) u_outreg (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (nxt_w),
    .q_o   (out_w)
  );

  assign len_o        = out_w.len;
  assign rd_o         = out_w.rd;
  assign rs_o         = out_w.rs;
  assign rz_o         = out_w.rz;
  assign scale_o      = out_w.scale;
  assign imm_o        = out_w.imm;
  assign tgt_o        = out_w.tgt;
  assign is_stop_o    = out_w.kind.stop;
  assign is_ret_o     = out_w.kind.ret;
  assign is_alu_rr_o  = out_w.kind.alu_rr;
  assign is_alu_ri_o  = out_w.kind.alu_ri;
  assign is_mov_o     = out_w.kind.mov;
  assign is_load_o    = out_w.kind.load;
  assign is_store_o   = out_w.kind.store;
  assign is_lea_o     = out_w.kind.lea;
  assign is_call_o    = out_w.kind.call;
  assign is_jmp_o     = out_w.kind.jmp;
  assign is_cbr_o     = out_w.kind.cbr;
  assign is_illegal_o = out_w.kind.illegal;

  // R1: only the five format lengths ever appear
  a_r1_len_in_set: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_w.len inside {LEN_W'(2), LEN_W'(3), LEN_W'(6), LEN_W'(7), LEN_W'(10)}));

  // R11: one class per decode
  a_r11_single_class: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(nxt_w.kind));

  // R3: an illegal decode is short and carries no fields
  a_r3_illegal_short: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_w.kind.illegal |-> (nxt_w.len == LEN_W'(2) && nxt_w.imm == '0 && nxt_w.tgt == '0));

  // R8: short formats carry no immediate
  a_r8_imm_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_w.len < LEN_W'(6)) |-> (nxt_w.imm == '0));

  // R9: a target appears only on control transfers, and is never sign-filled
  a_r9_tgt_only_flow: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_w.tgt != '0) |-> ((nxt_w.kind.call || nxt_w.kind.jmp || nxt_w.kind.cbr) &&
                           (nxt_w.tgt[XLEN-1:FIELD_W] == '0)));
endmodule

// File: tb/vlen_insn_decoder_tb.sv
module vlen_insn_decoder_tb;
  logic        clk;
  logic        rst_n;
  logic [79:0] insn_i;
  logic [3:0]  len_o, rd_o, rs_o, rz_o;
  logic [1:0]  scale_o;
  logic [63:0] imm_o, tgt_o;
  logic is_stop_o, is_ret_o, is_alu_rr_o, is_alu_ri_o, is_mov_o, is_load_o;
  logic is_store_o, is_lea_o, is_call_o, is_jmp_o, is_cbr_o, is_illegal_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [7:0] bb [10];

  // expected values
  logic [3:0]  e_len;
  logic [11:0] e_kind;
  logic [63:0] e_imm, e_tgt;
  string       e_tag;

  vlen_insn_decoder #(.REG_OUT(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .insn_i(insn_i),
    .len_o(len_o), .rd_o(rd_o), .rs_o(rs_o), .rz_o(rz_o), .scale_o(scale_o),
    .imm_o(imm_o), .tgt_o(tgt_o),
    .is_stop_o(is_stop_o), .is_ret_o(is_ret_o), .is_alu_rr_o(is_alu_rr_o),
    .is_alu_ri_o(is_alu_ri_o), .is_mov_o(is_mov_o), .is_load_o(is_load_o),
    .is_store_o(is_store_o), .is_lea_o(is_lea_o), .is_call_o(is_call_o),
    .is_jmp_o(is_jmp_o), .is_cbr_o(is_cbr_o), .is_illegal_o(is_illegal_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [11:0] act_kind();
    return {is_stop_o, is_ret_o, is_alu_rr_o, is_alu_ri_o, is_mov_o, is_load_o,
            is_store_o, is_lea_o, is_call_o, is_jmp_o, is_cbr_o, is_illegal_o};
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s op=%02h b1=%02h b2=%02h actual=%0h expected=%0h",
               tag, what, bb[0], bb[1], bb[2], act, exp);
    end
  endtask

  // little-endian 32-bit value from the byte array, built arithmetically
  function automatic longint le_val(input int start);
    longint v = 0;
    for (int k = 3; k >= 0; k--) v = v * 256 + longint'(bb[start + k]);
    return v;
  endfunction

  task automatic model();
    int op, mj, mn, sc;
    bit ok_cond;
    longint v;
    op = int'(bb[0]); mj = op / 16; mn = op % 16; sc = int'(bb[2]) % 16;
    ok_cond = (mn == 0) || (mn == 1) || (mn >= 4 && mn <= 11);
    e_kind = '0; e_imm = '0; e_tgt = '0;
    // bit order: stop ret alu_rr alu_ri mov load store lea call jmp cbr illegal
    if (op == 'h00 && bb[1] == 8'h00)              e_kind[11] = 1;
    else if (op == 'h01 && bb[1] < 8'h10)          e_kind[10] = 1;
    else if (mj == 1 && mn <= 9)                   e_kind[9] = 1;
    else if (mj == 5 && mn <= 9)                   e_kind[8] = 1;
    else if (op == 'h21 || op == 'h64)             e_kind[7] = 1;
    else if (op == 'h31 || op == 'h75)             e_kind[6] = 1;
    else if (op == 'h39 || op == 'h7D)             e_kind[5] = 1;
    else if (op == 'h81 || op == 'hA4 || op == 'hA5) e_kind[4] = 1;
    else if ((op == 'h92 || op == 'h93 || op == 'hB6 || op == 'hB7) && sc < 4) e_kind[4] = 1;
    else if (op == 'h4E)                           e_kind[3] = 1;
    else if (op == 'h4F)                           e_kind[2] = 1;
    else if ((mj == 4 || mj == 15) && ok_cond)     e_kind[1] = 1;
    else                                           e_kind[0] = 1;

    if (e_kind[0]) e_len = 2;
    else if (mj == 9) e_len = 3;
    else if (mj == 11) e_len = 7;
    else if (mj == 15) e_len = 10;
    else if (mj >= 4 && mj <= 7 || mj == 10) e_len = 6;
    else e_len = 2;

    if (!e_kind[0]) begin
      if (mj == 5 || mj == 6 || mj == 7 || mj == 10 || mj == 15) begin
        v = le_val(2); if (v >= 64'sh8000_0000) v = v - 64'sh1_0000_0000;
        e_imm = 64'(v);
      end else if (mj == 11) begin
        v = le_val(3); if (v >= 64'sh8000_0000) v = v - 64'sh1_0000_0000;
        e_imm = 64'(v);
      end
      if (mj == 4)  e_tgt = 64'(le_val(2));
      if (mj == 15) e_tgt = 64'(le_val(6));
    end

    if (e_kind[0]) e_tag = "R3";
    else if (e_kind[11] || e_kind[10]) e_tag = "R4";
    else if (e_kind[6] || e_kind[5]) e_tag = "R5";
    else if (e_kind[3] || e_kind[2] || e_kind[1]) e_tag = "R6";
    else e_tag = "R7";
  endtask

  task automatic drive();
    for (int k = 0; k < 10; k++) insn_i[8*k +: 8] = bb[k];
  endtask

  task automatic check_all();
    chk("R1", "len", 64'(len_o), 64'(e_len));
    chk(e_tag, "class", 64'(act_kind()), 64'(e_kind));
    chk("R11", "onehot", 64'($countones(act_kind())), 64'd1);
    chk("R2", "regs", {48'd0, rd_o, rs_o, rz_o, 2'b00, scale_o},
        {48'd0, bb[1], bb[2][7:4], 2'b00, bb[2][1:0]});
    chk("R8", "imm", imm_o, e_imm);
    chk("R9", "tgt", tgt_o, e_tgt);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] b1v [3];
    logic [7:0] pat [3][8];
    b1v[0] = 8'h00; b1v[1] = 8'h0F; b1v[2] = 8'h5A;
    pat[0] = '{8'h30, 8'h00, 8'h00, 8'h00, 8'h78, 8'h56, 8'h34, 8'h92};
    pat[1] = '{8'h02, 8'hA1, 8'hB2, 8'hC3, 8'h84, 8'h11, 8'h22, 8'h33};
    pat[2] = '{8'h1D, 8'hFE, 8'h7F, 8'h80, 8'hFF, 8'h05, 8'h06, 8'h47};

    rst_n = 1'b0;
    for (int k = 0; k < 10; k++) bb[k] = 8'h4F;
    drive();
    repeat (3) @(negedge clk);
    // R10: reset clears every output even with a legal instruction applied
    chk("R10", "reset len", 64'(len_o), 64'd0);
    chk("R10", "reset flags", 64'(act_kind()), 64'd0);
    chk("R10", "reset imm/tgt", imm_o | tgt_o, 64'd0);
    rst_n = 1'b1;

    // R10: registered stage, output changes only after the next rising edge
    @(negedge clk);
    for (int k = 0; k < 10; k++) bb[k] = 8'h00;
    drive();
    #2;
    chk("R10", "hold before edge", 64'(is_jmp_o), 64'd1);
    @(negedge clk);
    chk("R10", "after edge", 64'(is_stop_o), 64'd1);

    for (int p = 0; p < 3; p++) begin
      for (int j = 0; j < 3; j++) begin
        for (int op = 0; op < 256; op++) begin
          bb[0] = 8'(op);
          bb[1] = b1v[j];
          for (int k = 0; k < 8; k++) bb[k + 2] = pat[p][k];
          drive();
          model();
          @(negedge clk);
          check_all();
        end
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule